// File: doc/BRIEF.md
# Latched Serial-to-Parallel Shift Register

The block turns a serial bit stream into a parallel word in two separate steps. A shift stage takes one bit per rising edge of a shift strobe. A storage stage copies the whole shift stage in one step, on a rising edge of a separate store strobe. The parallel outputs show only the storage stage. A new word can therefore be shifted in while the previous word stays steady on the outputs. The last shift bit is brought out as a chain output, so several blocks can be cascaded into a longer word.

Both strobes are ordinary data inputs. They are sampled on the single system clock `clk`, and a small two-state edge machine per strobe turns each low-to-high transition into a one-cycle pulse. The states are `LVL_LO` (last sample low) and `LVL_HI` (last sample high). The transitions are:
- `LVL_LO -> LVL_HI` when the strobe is sampled high. The rise pulse is raised in this cycle.
- `LVL_HI -> LVL_LO` when the strobe is sampled low. No pulse is raised.
- Each state holds while the strobe keeps its level.

An active-low clear empties the shift stage only. An active-low output enable lets the stored word onto `par_out`. When disabled, the outputs go to zero and `par_valid` drops; this stands in for a high-impedance output.

Top module: `staged_sipo`

## Requirements
- R1: In a cycle where a shift rise is detected and `clr_n` is high, the shift stage moves one place toward the last stage: bit i goes to bit i+1, and `ser_in` enters bit 0. The result is visible after that clock edge.
- R2: A falling `shift_clk`, or a `shift_clk` held high, leaves the shift stage unchanged.
- R3: A detected store rise copies the whole shift stage into the storage stage. A falling `store_clk` changes nothing.
- R4: `par_out` shows only the storage stage. It stays constant while bits are being shifted in.
- R5: While `clr_n` is sampled low, the shift stage is zero. The storage stage is not affected by the clear.
- R6: With `oe_n` high, `par_out` is all zeros and `par_valid` is 0. With `oe_n` low, `par_out` equals the stored word and `par_valid` is 1.
- R7: `chain_out` always equals the last shift stage, bit WIDTH-1.
- R8: If a shift rise and a store rise are detected in the same cycle, the storage stage captures the shift stage as it was before that shift.
- R9: A store rise detected while `clr_n` is low latches all zeros.
- R10: After `rst_n` is asserted, the shift stage, the storage stage and both edge machines are cleared, with the edge machines in `LVL_LO`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_in | input | 1 | Serial data bit |
| shift_clk | input | 1 | Shift strobe, acts on its rising edge |
| store_clk | input | 1 | Store strobe, acts on its rising edge |
| clr_n | input | 1 | Active-low clear of the shift stage |
| oe_n | input | 1 | Active-low output enable |
| par_out | output | WIDTH | Stored word, or zero when disabled |
| par_valid | output | 1 | High while the outputs are enabled |
| chain_out | output | 1 | Last shift-stage bit, for cascading |

## Verification
Two functions can fall in the same system-clock cycle: a shift and a store, and likewise a clear and a store. The bench provokes each case by raising both strobes in one cycle, or by raising the store strobe while the clear is held low. The scoreboard model then expects the stored word to be the shift contents before that edge, or all zeros under clear. These expectations are compared at `par_out` in the cycle after the edge. The shift contents are confirmed separately, bit by bit, through `chain_out`.

// File: rtl/staged_sipo_pkg.sv
package staged_sipo_pkg;
    typedef enum logic {
        LVL_LO = 1'b0,
        LVL_HI = 1'b1
    } lvl_e;

    localparam int unsigned NUM_STROBES = 2;
    localparam int unsigned STB_SHIFT   = 0;
    localparam int unsigned STB_STORE   = 1;
endpackage

// File: rtl/sipo_edge_fsm.sv
module sipo_edge_fsm
    import staged_sipo_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise
);
    lvl_e cur_st, nxt_st;

    always_comb begin
        nxt_st = cur_st;
        unique case (cur_st)
            LVL_LO: if (pin)  nxt_st = LVL_HI;
            LVL_HI: if (!pin) nxt_st = LVL_LO;
            default:          nxt_st = LVL_LO;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_st <= LVL_LO;
        else        cur_st <= nxt_st;
    end

    always_comb begin
        rise = 1'b0;
        unique case (cur_st)
            LVL_LO:  rise = pin;
            LVL_HI:  rise = 1'b0;
            default: rise = 1'b0;
        endcase
    end
endmodule

// File: rtl/sipo_shift_stage.sv
module sipo_shift_stage #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_n,
    input  logic             step,
    input  logic             ser_in,
    output logic [WIDTH-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      q <= '0;
        else if (!clr_n) q <= '0;
        else if (step)   q <= {q[WIDTH-2:0], ser_in};
    end
endmodule

// File: rtl/sipo_store_stage.sv
module sipo_store_stage #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_n,
    input  logic             load,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= clr_n ? d : '0;
    end
endmodule

// File: rtl/staged_sipo.sv
module staged_sipo
    import staged_sipo_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_in,
    input  logic             shift_clk,
    input  logic             store_clk,
    input  logic             clr_n,
    input  logic             oe_n,
    output logic [WIDTH-1:0] par_out,
    output logic             par_valid,
    output logic             chain_out
);
    logic [NUM_STROBES-1:0] strobe_pin;
    logic [NUM_STROBES-1:0] strobe_rise;
    logic [WIDTH-1:0]       shift_q;
    logic [WIDTH-1:0]       store_q;
    logic                   shift_rise;
    logic                   store_rise;

    assign strobe_pin[STB_SHIFT] = shift_clk;
    assign strobe_pin[STB_STORE] = store_clk;

    for (genvar g = 0; g < NUM_STROBES; g++) begin : g_edge
        sipo_edge_fsm u_edge (
            .clk  (clk),
            .rst_n(rst_n),
            .pin  (strobe_pin[g]),
            .rise (strobe_rise[g])
        );
    end

    assign shift_rise = strobe_rise[STB_SHIFT];
    assign store_rise = strobe_rise[STB_STORE];

    sipo_shift_stage #(.WIDTH(WIDTH)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_n (clr_n),
        .step  (shift_rise),
        .ser_in(ser_in),
        .q     (shift_q)
    );

    sipo_store_stage #(.WIDTH(WIDTH)) u_store (
        .clk  (clk),
        .rst_n(rst_n),
        .clr_n(clr_n),
        .load (store_rise),
        .d    (shift_q),
        .q    (store_q)
    );

    always_comb begin
        par_out   = oe_n ? '0 : store_q;
        par_valid = ~oe_n;
        chain_out = shift_q[WIDTH-1];
    end
endmodule

// File: rtl/staged_sipo_chk.sv
module staged_sipo_chk #(
    parameter int unsigned WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr_n,
    input logic             oe_n,
    input logic             shift_rise,
    input logic             store_rise,
    input logic [WIDTH-1:0] shift_q,
    input logic [WIDTH-1:0] store_q,
    input logic [WIDTH-1:0] par_out,
    input logic             chain_out
);
    // R1
    shift_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_rise && clr_n) |=> (chain_out == $past(shift_q[WIDTH-2])));
    // R2
    shift_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_rise && clr_n) |=> $stable(shift_q));
    // R4
    store_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !store_rise |=> $stable(store_q));
    // R5
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |=> (shift_q == '0));
    // R6
    oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> (par_out == '0));
    // R8
    same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (store_rise && shift_rise && clr_n) |=> (store_q == $past(shift_q)));
    // R9
    store_in_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (store_rise && !clr_n) |=> (store_q == '0));
endmodule

bind staged_sipo staged_sipo_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_n     (clr_n),
    .oe_n      (oe_n),
    .shift_rise(shift_rise),
    .store_rise(store_rise),
    .shift_q   (shift_q),
    .store_q   (store_q),
    .par_out   (par_out),
    .chain_out (chain_out)
);

// File: tb/staged_sipo_tb.sv
module staged_sipo_tb;
    localparam int W = 8;

    typedef struct {
        logic [W-1:0] par;
        logic         valid;
        logic         chain;
        string        tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_in = 1'b0, shift_clk = 1'b0, store_clk = 1'b0;
    logic clr_n = 1'b1, oe_n = 1'b0;
    logic [W-1:0] par_out;
    logic par_valid, chain_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    exp_t q_exp[$];

    logic [W-1:0] m_sh = '0, m_st = '0;
    logic m_ps = 1'b0, m_pr = 1'b0;

    always #5 clk = ~clk;

    staged_sipo #(.WIDTH(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .shift_clk(shift_clk),
        .store_clk(store_clk), .clr_n(clr_n), .oe_n(oe_n),
        .par_out(par_out), .par_valid(par_valid), .chain_out(chain_out)
    );

    // one system-clock cycle with given inputs; model predicts outputs after the edge
    task automatic step(input logic s, input logic sck, input logic rck,
                        input logic clr, input logic oe, input string tag);
        exp_t e;
        logic rs, rr;
        @(negedge clk);
        ser_in = s; shift_clk = sck; store_clk = rck; clr_n = clr; oe_n = oe;
        @(posedge clk);
        rs = sck && !m_ps;
        rr = rck && !m_pr;
        if (rr) m_st = clr ? m_sh : '0;
        if (!clr) m_sh = '0;
        else if (rs) m_sh = {m_sh[W-2:0], s};
        m_ps = sck; m_pr = rck;
        e.par = oe ? '0 : m_st;
        e.valid = !oe;
        e.chain = m_sh[W-1];
        e.tag = tag;
        q_exp.push_back(e);
    endtask

    task automatic shift_byte(input logic [W-1:0] b, input string tag);
        for (int i = W - 1; i >= 0; i--) begin
            step(b[i], 1'b1, 1'b0, 1'b1, 1'b0, tag);
            step(b[i], 1'b0, 1'b0, 1'b1, 1'b0, tag);
        end
    endtask

    task automatic store_pulse(input string tag);
        step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, tag);
        step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, tag);
    endtask

    // monitor: compare a little after each active edge
    always @(posedge clk) begin
        #3;
        while (q_exp.size() > 0) begin
            exp_t e;
            e = q_exp.pop_front();
            checks++;
            if (par_out !== e.par || par_valid !== e.valid || chain_out !== e.chain) begin
                errors++;
                $display("FAIL %s: par=%h valid=%b chain=%b expected par=%h valid=%b chain=%b",
                         e.tag, par_out, par_valid, chain_out, e.par, e.valid, e.chain);
            end
        end
    end

    initial begin
        #200_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (par_out !== '0 || chain_out !== 1'b0 || par_valid !== 1'b1) begin
            errors++;
            $display("FAIL R10 reset: par=%h chain=%b valid=%b expected par=00 chain=0 valid=1",
                     par_out, chain_out, par_valid);
        end
        rst_n = 1'b1;

        // R1 R7 R4: shift 3F, outputs stay at zero while shifting
        shift_byte(8'h3F, "R1/R4/R7 shift 3F");
        // R3: store pulse copies
        store_pulse("R3 store 3F");
        // R4: shift 06 while 3F is shown
        shift_byte(8'h06, "R4 hold while shifting 06");
        store_pulse("R3 store 06");
        // R2: shift strobe held high shifts once only
        step(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, "R2 first rise");
        step(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, "R2 held high");
        step(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, "R2 held high");
        step(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R2 falling");
        // R3: store held high then falling changes nothing
        step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R3 store rise");
        step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R3 store held");
        step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R3 store falling");
        // R6: disable then enable outputs
        step(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R6 disabled");
        step(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R6 disabled");
        step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R6 enabled");
        // R8: shift and store rise together
        shift_byte(8'hA5, "R7 shift A5");
        step(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R8 simultaneous");
        step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R8 after");
        store_pulse("R8 store post-shift");
        // R5: clear empties shift stage, storage untouched
        shift_byte(8'hFF, "R7 shift FF");
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R5 clear");
        step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R5 shift during clear");
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R5 clear held");
        // R9: store edge during clear latches zeros
        step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R9 store in clear");
        step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R9 after clear");
        // R9: store in the very cycle clear is first low
        shift_byte(8'h81, "R7 shift 81");
        step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R9 store with first clear cycle");
        step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R9 after");

        @(posedge clk); #4;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule